// File: doc/BRIEF.md
# Pending Breakpoint Acknowledge Controller

This block sits between external debug logic and the exception sequencer of a processor core. Breakpoint requests never interrupt the core directly. They are latched as pending, and an acknowledge read is issued on the bus only when the core reaches a safe point: either an instruction boundary or the end of exception processing.

The way the bus ends that read decides what happens next. A normal termination drops the acknowledged requests, and the core carries on with the next instruction as if nothing had been asked. A bus-error termination makes the block raise a breakpoint exception request. That request carries a fixed vector number and its byte offset. It comes with a one-cycle strobe that tells the core to capture the current PC, the next PC and the status word for stacking.

There are two kinds of request. A plain request becomes pending at once. An instruction-tied request is only armed at first, and it becomes pending when the instruction it belongs to retires. Requests that arrive while an acknowledge is in flight are kept for a later acknowledge.

Top module: `bkpt_ack_ctrl`

## Requirements
- R1: A request on `bkpt_req_i` is latched as pending. It never starts an acknowledge or an exception in the cycle it arrives. No acknowledge starts while nothing is pending.
- R2: A request on `ibkpt_req_i` is only armed. It becomes pending in the cycle `retire_i` is high, and this includes an arming request in that same cycle. Before that retire, a safe point starts no acknowledge.
- R3: The acknowledge cycle (`bus_req_o` high) begins one cycle after a clock edge at which a breakpoint was already registered as pending and either `insn_bound_i` or `exc_done_i` was high. It begins at no other time.
- R4: While the acknowledge runs, `bus_rd_o` is 1 and `bus_fc_o` is 3'b111 (CPU space). `bus_addr_o` holds space type 0 in bits [19:16] and location 0x1E in the low bits, which gives 0x00001E. Outside the acknowledge, all three outputs are 0.
- R5: A normal termination (`bus_done_i` high and `bus_err_i` low) ends the acknowledge and clears the acknowledged requests. No exception request follows, and a later safe point starts no new acknowledge unless a new request has arrived.
- R6: A bus-error termination makes `exc_req_o` and `ctx_latch_o` high for exactly one cycle, on the cycle after the termination. During that cycle `exc_vec_o` is 12. Otherwise both strobes are 0 and `exc_vec_o` is 0.
- R7: If `bus_done_i` and `bus_err_i` are both high, the bus error wins and the exception is raised.
- R8: A request that arrives while the acknowledge is in flight stays pending after the termination, and it is acknowledged at a later safe point.
- R9: `exc_off_o` always equals `exc_vec_o` multiplied by four, which gives 0x30 for the breakpoint vector.
- R10: A synchronous active-high `rst` clears all pending and armed requests and returns the block to idle, with every output at 0.
- R11: Once started, the acknowledge stays asserted until `bus_done_i` or `bus_err_i` ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bkpt_req_i | input | N_BKPT | Breakpoint requests that become pending at once |
| ibkpt_req_i | input | N_BKPT | Instruction-tied breakpoint requests, armed until retire |
| retire_i | input | 1 | The current instruction has completed execution |
| insn_bound_i | input | 1 | The core is between instructions |
| exc_done_i | input | 1 | Exception processing has completed |
| bus_done_i | input | 1 | Normal termination of the acknowledge read |
| bus_err_i | input | 1 | Bus-error termination of the acknowledge read |
| bus_req_o | output | 1 | Acknowledge bus cycle requested |
| bus_rd_o | output | 1 | Read direction of the acknowledge cycle |
| bus_fc_o | output | 3 | Cycle type, 3'b111 is CPU space |
| bus_addr_o | output | ADDR_W | Acknowledge address |
| exc_req_o | output | 1 | Take-breakpoint-exception request |
| exc_vec_o | output | 8 | Exception vector number |
| exc_off_o | output | 10 | Exception vector offset |
| ctx_latch_o | output | 1 | Strobe to latch current PC, next PC and status word |

## Verification
If a pending flag is wrong, it appears at the next safe point. A lost flag leaves `bus_req_o` low when it should rise. A stale flag starts an acknowledge that should not happen. In both cases the error shows one cycle after the strobe. If the state machine is wrong after a termination, it shows on the very next cycle: `exc_req_o` pulses when it should stay low or stays low when it should pulse, or `bus_req_o` stays high. An instruction-tied request that is committed too early or too late shows as an acknowledge that starts before its retire, or as one missing after its retire.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PEND  = 2'd1,
    ST_ACK   = 2'd2,
    ST_RAISE = 2'd3
  } bk_state_e;

  localparam int VEC_W = 8;
  localparam int OFF_W = VEC_W + 2;

  // CPU-space cycle type and acknowledge location
  localparam logic [2:0] FC_CPU_SPACE = 3'b111;
  localparam logic [3:0] SPACE_BKPT   = 4'h0;
  localparam logic [7:0] ACK_LOC      = 8'h1E;
  localparam int         SPACE_LSB    = 16;

  localparam logic [VEC_W-1:0] BKPT_VEC = VEC_W'(12);

  // vector number to byte offset in the vector table
  function automatic logic [OFF_W-1:0] vec_to_off(input logic [VEC_W-1:0] v);
    return {v, 2'b00};
  endfunction

endpackage

// File: rtl/bkpt_pend_track.sv
module bkpt_pend_track #(
  parameter int N_BKPT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_BKPT-1:0] bkpt_req_i,
  input  logic [N_BKPT-1:0] ibkpt_req_i,
  input  logic              retire_i,
  input  logic              ack_start_i,
  input  logic              ack_end_i,
  output logic              any_pend_o,
  output logic              any_pend_next_o
);

  logic [N_BKPT-1:0] pend_q, pend_d;
  logic [N_BKPT-1:0] arm_q, arm_d;
  logic [N_BKPT-1:0] ackset_q;
  logic [N_BKPT-1:0] commit_w;
  logic [N_BKPT-1:0] clr_w;

  always_comb begin
    commit_w = retire_i ? (arm_q | ibkpt_req_i) : '0;
    clr_w    = ack_end_i ? ackset_q : '0;
    pend_d   = (pend_q & ~clr_w) | bkpt_req_i | commit_w;
    arm_d    = retire_i ? '0 : (arm_q | ibkpt_req_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      arm_q    <= '0;
      ackset_q <= '0;
    end else begin
      pend_q <= pend_d;
      arm_q  <= arm_d;
      if (ack_start_i) ackset_q <= pend_q;
    end
  end

  assign any_pend_o      = |pend_q;
  assign any_pend_next_o = |pend_d;

  AST_ARMED_WAITS_RETIRE: assert property (@(posedge clk) disable iff (rst)
    (pend_q == '0 && bkpt_req_i == '0 && !retire_i) |=> (pend_q == '0)); // R2

  AST_LATE_REQ_KEPT: assert property (@(posedge clk) disable iff (rst)
    (ack_end_i && bkpt_req_i != '0) |=> any_pend_o); // R8

endmodule

// File: rtl/bkpt_ack_fsm.sv
module bkpt_ack_fsm
  import bkpt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      any_pend_i,
  input  logic      any_pend_next_i,
  input  logic      insn_bound_i,
  input  logic      exc_done_i,
  input  logic      bus_done_i,
  input  logic      bus_err_i,
  output logic      ack_start_o,
  output logic      ack_end_o,
  output logic      ack_active_o,
  output logic      raise_o
);

  bk_state_e state_q, state_d;
  logic      safe_w;

  assign safe_w = insn_bound_i | exc_done_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (any_pend_next_i) state_d = ST_PEND;
      ST_PEND:  if (safe_w) state_d = ST_ACK;
      ST_ACK: begin
        if (bus_err_i)       state_d = ST_RAISE;
        else if (bus_done_i) state_d = any_pend_next_i ? ST_PEND : ST_IDLE;
      end
      ST_RAISE: state_d = any_pend_next_i ? ST_PEND : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign ack_start_o  = (state_q == ST_PEND) && safe_w;
  assign ack_active_o = (state_q == ST_ACK);
  assign ack_end_o    = (state_q == ST_ACK) && (bus_done_i || bus_err_i);
  assign raise_o      = (state_q == ST_RAISE);

  AST_PEND_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PEND) |-> any_pend_i); // R1

  AST_ACK_AT_SAFE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACK && $past(state_q) != ST_ACK) |-> $past(safe_w)); // R3

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACK && !bus_done_i && !bus_err_i) |=> (state_q == ST_ACK)); // R11

  AST_ERR_RAISES: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACK && bus_err_i) |=> (state_q == ST_RAISE)); // R7

  AST_DONE_RESUMES: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACK && bus_done_i && !bus_err_i) |=>
      (state_q != ST_RAISE && state_q != ST_ACK)); // R5

  AST_RAISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RAISE) |=> (state_q != ST_RAISE)); // R6

endmodule

// File: rtl/bkpt_exc_out.sv
module bkpt_exc_out
  import bkpt_pkg::*;
(
  input  logic             raise_i,
  output logic             exc_req_o,
  output logic             ctx_latch_o,
  output logic [VEC_W-1:0] exc_vec_o,
  output logic [OFF_W-1:0] exc_off_o
);

  assign exc_req_o   = raise_i;
  assign ctx_latch_o = raise_i;
  assign exc_vec_o   = raise_i ? BKPT_VEC : '0;
  assign exc_off_o   = vec_to_off(exc_vec_o);

endmodule

// File: rtl/bkpt_ack_ctrl.sv
module bkpt_ack_ctrl
  import bkpt_pkg::*;
#(
  parameter int N_BKPT = 2,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_BKPT-1:0] bkpt_req_i,
  input  logic [N_BKPT-1:0] ibkpt_req_i,
  input  logic              retire_i,
  input  logic              insn_bound_i,
  input  logic              exc_done_i,
  input  logic              bus_done_i,
  input  logic              bus_err_i,
  output logic              bus_req_o,
  output logic              bus_rd_o,
  output logic [2:0]        bus_fc_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              exc_req_o,
  output logic [VEC_W-1:0]  exc_vec_o,
  output logic [OFF_W-1:0]  exc_off_o,
  output logic              ctx_latch_o
);

  localparam logic [ADDR_W-1:0] ACK_ADDR =
    (ADDR_W'(SPACE_BKPT) << SPACE_LSB) | ADDR_W'(ACK_LOC);

  logic any_pend_w, any_pend_next_w;
  logic ack_start_w, ack_end_w, ack_active_w, raise_w;

  bkpt_pend_track #(.N_BKPT(N_BKPT)) u_pend (
    .clk             (clk),
    .rst             (rst),
    .bkpt_req_i      (bkpt_req_i),
    .ibkpt_req_i     (ibkpt_req_i),
    .retire_i        (retire_i),
    .ack_start_i     (ack_start_w),
    .ack_end_i       (ack_end_w),
    .any_pend_o      (any_pend_w),
    .any_pend_next_o (any_pend_next_w)
  );

  bkpt_ack_fsm u_fsm (
    .clk             (clk),
    .rst             (rst),
    .any_pend_i      (any_pend_w),
    .any_pend_next_i (any_pend_next_w),
    .insn_bound_i    (insn_bound_i),
    .exc_done_i      (exc_done_i),
    .bus_done_i      (bus_done_i),
    .bus_err_i       (bus_err_i),
    .ack_start_o     (ack_start_w),
    .ack_end_o       (ack_end_w),
    .ack_active_o    (ack_active_w),
    .raise_o         (raise_w)
  );

  bkpt_exc_out u_exc (
    .raise_i     (raise_w),
    .exc_req_o   (exc_req_o),
    .ctx_latch_o (ctx_latch_o),
    .exc_vec_o   (exc_vec_o),
    .exc_off_o   (exc_off_o)
  );

  assign bus_req_o  = ack_active_w;
  assign bus_rd_o   = ack_active_w;
  assign bus_fc_o   = ack_active_w ? FC_CPU_SPACE : 3'b000;
  assign bus_addr_o = ack_active_w ? ACK_ADDR : '0;

  AST_ACK_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req_o) |-> $past(any_pend_w)); // R1

  AST_ACK_ENCODING: assert property (@(posedge clk) disable iff (rst)
    bus_req_o |-> (bus_fc_o == 3'b111 && bus_addr_o == ADDR_W'(24'h00001E) && bus_rd_o)); // R4

  AST_EXC_VECTOR: assert property (@(posedge clk) disable iff (rst)
    exc_req_o |-> (exc_vec_o == 8'd12 && exc_off_o == 10'h030 && ctx_latch_o)); // R9

  AST_ERR_GIVES_EXC: assert property (@(posedge clk) disable iff (rst)
    (bus_req_o && bus_err_i) |=> exc_req_o); // R6

endmodule

// File: tb/sim_bkpt_ack_ctrl.sv
`timescale 1ns/1ps
module sim_bkpt_ack_ctrl;

  localparam int N = 2;
  localparam int AW = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] bkpt_req = '0, ibkpt_req = '0;
  logic retire = 0, ib = 0, ed = 0, dn = 0, er = 0;
  logic bus_req, bus_rd, exc_req, ctx_latch;
  logic [2:0] bus_fc;
  logic [AW-1:0] bus_addr;
  logic [7:0] exc_vec;
  logic [9:0] exc_off;

  int checks = 0, failures = 0, ncyc = 0;
  bit finished = 0;

  // bench model: 0 = idle/pending, 1 = acknowledging, 2 = raising
  int m_st = 0;
  logic [N-1:0] m_pend = '0, m_arm = '0, m_ackset = '0;

  always #10 clk = ~clk;

  bkpt_ack_ctrl #(.N_BKPT(N), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .bkpt_req_i(bkpt_req), .ibkpt_req_i(ibkpt_req),
    .retire_i(retire), .insn_bound_i(ib), .exc_done_i(ed),
    .bus_done_i(dn), .bus_err_i(er), .bus_req_o(bus_req), .bus_rd_o(bus_rd),
    .bus_fc_o(bus_fc), .bus_addr_o(bus_addr), .exc_req_o(exc_req),
    .exc_vec_o(exc_vec), .exc_off_o(exc_off), .ctx_latch_o(ctx_latch)
  );

  function automatic int exp_off(input int vec);
    return vec * 4;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    int ev;
    ev = (m_st == 2) ? 12 : 0;
    chk("R3 bus_req", bus_req, m_st == 1);
    chk("R4 bus_rd", bus_rd, m_st == 1);
    chk("R4 bus_fc", bus_fc, (m_st == 1) ? 7 : 0);
    chk("R4 bus_addr", bus_addr, (m_st == 1) ? 'h1E : 0);
    chk("R6 exc_req", exc_req, m_st == 2);
    chk("R6 ctx_latch", ctx_latch, m_st == 2);
    chk("R6 exc_vec", exc_vec, ev);
    chk("R9 exc_off", exc_off, exp_off(ev));
  endtask

  task automatic cyc(input logic [N-1:0] rq, input logic [N-1:0] irq,
                     input logic rt, input logic b, input logic e,
                     input logic d, input logic r);
    int nst;
    logic [N-1:0] clr, nack, npend, narm;
    bkpt_req = rq; ibkpt_req = irq; retire = rt; ib = b; ed = e; dn = d; er = r;
    nst = m_st; clr = '0; nack = m_ackset;
    if (m_st == 0) begin
      if (m_pend != '0 && (b || e)) begin nst = 1; nack = m_pend; end
    end else if (m_st == 1) begin
      if (r)      begin nst = 2; clr = m_ackset; end
      else if (d) begin nst = 0; clr = m_ackset; end
    end else nst = 0;
    npend = (m_pend & ~clr) | rq | (rt ? (m_arm | irq) : '0);
    narm  = rt ? '0 : (m_arm | irq);
    @(posedge clk);
    m_st = nst; m_pend = npend; m_arm = narm; m_ackset = nack;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc('0, '0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      ncyc++;
      if (ncyc > 150000 && !finished) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=done", ncyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd7));
    // R10: reset with pending and armed requests present
    repeat (2) @(negedge clk);
    bkpt_req = 2'b11; ibkpt_req = 2'b01;
    @(negedge clk);
    bkpt_req = '0; ibkpt_req = '0;
    rst = 1'b0;
    compare();
    chk("R10 bus_req after reset", bus_req, 0);
    chk("R10 exc_req after reset", exc_req, 0);
    cyc('0, '0, 0, 1, 0, 0, 0);
    chk("R10 no ack after reset cleared requests", bus_req, 0);

    // R1: latched, not taken without a safe point
    cyc(2'b01, '0, 0, 0, 0, 0, 0);
    chk("R1 no ack on request cycle", bus_req, 0);
    idle(3);
    chk("R1 still waiting", bus_req, 0);
    cyc('0, '0, 0, 1, 0, 0, 0);
    chk("R3 ack after boundary", bus_req, 1);
    idle(3);
    chk("R11 ack held", bus_req, 1);
    cyc('0, '0, 0, 0, 0, 1, 0);
    chk("R5 ack ended", bus_req, 0);
    chk("R5 no exception", exc_req, 0);
    cyc('0, '0, 0, 1, 0, 0, 0);
    chk("R5 cleared, no new ack", bus_req, 0);

    // R2: armed request waits for retire
    cyc('0, 2'b10, 0, 0, 0, 0, 0);
    cyc('0, '0, 0, 1, 0, 0, 0);
    chk("R2 no ack before retire", bus_req, 0);
    cyc('0, '0, 1, 0, 0, 0, 0);
    cyc('0, '0, 0, 1, 0, 0, 0);
    chk("R2 ack after retire", bus_req, 1);
    cyc('0, '0, 0, 0, 0, 0, 1);
    chk("R6 exception after bus error", exc_req, 1);
    chk("R6 vector", exc_vec, 12);
    chk("R9 offset", exc_off, 'h30);
    idle(1);
    chk("R6 single pulse", exc_req, 0);

    // R3: end of exception is a safe point; R7: error wins
    cyc(2'b10, '0, 0, 0, 0, 0, 0);
    cyc('0, '0, 0, 0, 1, 0, 0);
    chk("R3 ack after exception end", bus_req, 1);
    cyc('0, '0, 0, 0, 0, 1, 1);
    chk("R7 error wins", exc_req, 1);
    idle(1);

    // R8: request during acknowledge is kept
    cyc(2'b01, '0, 0, 0, 0, 0, 0);
    cyc('0, '0, 0, 1, 0, 0, 0);
    cyc(2'b10, '0, 0, 0, 0, 0, 0);
    cyc('0, '0, 0, 0, 0, 1, 0);
    chk("R8 first ack done", bus_req, 0);
    cyc('0, '0, 0, 1, 0, 0, 0);
    chk("R8 late request acknowledged", bus_req, 1);
    cyc('0, '0, 0, 0, 0, 1, 0);
    cyc('0, '0, 0, 1, 0, 0, 0);
    chk("R8 nothing left", bus_req, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] rq, irq;
      for (int k = 0; k < N; k++) begin
        rq[k]  = ($urandom % 10) == 0;
        irq[k] = ($urandom % 6) == 0;
      end
      cyc(rq, irq, ($urandom % 3) == 0, ($urandom % 4) == 0,
          ($urandom % 16) == 0, ($urandom % 3) == 0, ($urandom % 5) == 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule